// File: doc/BRIEF.md
# Reference-Clock PLL Power and Lock Sequencer

This block decides when a serializer's clock-multiplying PLL, its serial I/O and its internal bias references are powered, and when the parallel port may treat captured data as valid. It runs on a free-running sampling clock that is much faster than the reference clock. It watches a two-bit mode select and the reference clock, which it samples. The PLL itself is not modelled here. The block only produces power enables and counts reference-clock cycles as a stand-in for the lock time. The PLL multiplies the reference by 14 to form the bit clock.

There are two ways to shut the PLL down. Mode 0 (both select bits low) is the full reset: it removes PLL power at once, without waiting for a clock edge, and it also drops the references. After leaving mode 0 the block waits a long cold lock time. The second way is a reference clock that stops, whether it is held high or held low. This removes PLL and serial I/O power but keeps the references alive. The first reference edge that follows wakes the PLL, and it then waits a shorter warm lock time.

The reference clock and the mode select each pass through a two-flop synchronizer before the state machine uses them. Only the immediate mode-0 gating of the enables uses the raw mode select. The block has no data stream, so all of its pins are plain control and status levels.

Top module: `pll_pwr_seq`

## Requirements
- R1: When `mode_sel` is 0, `pll_en`, `sio_en` and `data_valid` are low in the same cycle, with no clock edge needed. Within 3 sampling cycles, `seq_state` is 0 (off) and `refs_en` is low.
- R2: A nonzero `mode_sel` moves the block from off (0) to cold locking (`seq_state` 1) within 3 cycles, with `pll_en`, `sio_en` and `refs_en` high, but only while the reference is toggling. While the reference is stalled, the block stays off.
- R3: `data_valid` goes high only in ready (`seq_state` 3). Cold locking reaches ready after COLD_WAIT rising reference edges counted while in cold locking, and not after COLD_WAIT-1 edges.
- R4: If no reference edge is seen for STALL_CYC sampling cycles, the block enters stalled (`seq_state` 4) from either locking state or from ready. This holds whether the reference is stuck high or stuck low.
- R5: In stalled, `pll_en` and `sio_en` are low and `refs_en` stays high.
- R6: The first reference edge of either polarity seen in stalled moves the block to warm locking (`seq_state` 2) with `pll_en` high, within 3 cycles of that edge.
- R7: Warm locking reaches ready after WARM_WAIT rising reference edges, and not after WARM_WAIT-1 edges.
- R8: During and straight after reset, the state is off (0) and all enables and `data_valid` are low.
- R9: Mode 0 while stalled returns the block to off with `refs_en` low.
- R10: Each of the nonzero `mode_sel` values 1, 2 and 3 counts as leaving mode 0 and runs the same cold sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Reference clock, sampled as data |
| mode_sel | input | 2 | Mode select; 0 is the power-down reset mode |
| pll_en | output | 1 | PLL core power enable |
| sio_en | output | 1 | Serial I/O power enable |
| refs_en | output | 1 | Internal reference power enable |
| data_valid | output | 1 | Parallel data may be captured |
| seq_state | output | 3 | 0 off, 1 cold locking, 2 warm locking, 3 ready, 4 stalled |

## Verification
The bench drives its inputs on the falling edge of the sampling clock and counts the latency in sampling cycles.
- **Mode change:** a new `mode_sel` value shows in `seq_state` 3 cycles later. That is two synchronizer flops plus the state register.
- **Lock end:** a reference rising edge completes the lock 4 cycles after it is driven, because the edge also passes the lock counter.
- **Stall:** a stall is reported STALL_CYC+4 cycles after the last edge.
- **Mode-0 gating:** the enables react 1 ns after `mode_sel` changes.

Each lock boundary is checked twice: one edge short of the count with margin to spare, then once more 1 cycle after the final period ends. The stall boundary is checked 2 cycles before it is due and 1 cycle after. The mode sweep repeats the cold sequence for every nonzero mode value.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_OFF   = 3'd0,
    SEQ_COLD  = 3'd1,
    SEQ_WARM  = 3'd2,
    SEQ_READY = 3'd3,
    SEQ_STALL = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ref_edge_det.sv
module ref_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_raw,
  output logic rise_o,
  output logic edge_o
);
  logic ref_s;
  logic ref_prev;

  seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ref_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ref_raw),
    .q    (ref_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev <= 1'b0;
    else        ref_prev <= ref_s;
  end

  assign rise_o = ref_s & ~ref_prev;
  assign edge_o = ref_s ^ ref_prev;
endmodule

// File: rtl/ref_stall_mon.sv
module ref_stall_mon #(
  parameter int STALL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic stalled_o
);
  localparam int CW = $clog2(STALL_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STALL_CYC);

  logic [CW-1:0] quiet_q;

  // Starts saturated: no activity has been seen since reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              quiet_q <= LIMIT;
    else if (edge_i)         quiet_q <= '0;
    else if (quiet_q != LIMIT) quiet_q <= quiet_q + 1'b1;
  end

  assign stalled_o = (quiet_q == LIMIT);
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int COLD_WAIT = 2048,
  parameter int WARM_WAIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic warm_i,
  input  logic rise_i,
  output logic done_o
);
  localparam int MAXW = (COLD_WAIT > WARM_WAIT) ? COLD_WAIT : WARM_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] COLD_T = CW'(COLD_WAIT);
  localparam logic [CW-1:0] WARM_T = CW'(WARM_WAIT);
  localparam logic [CW-1:0] SAT    = CW'(MAXW);

  logic [CW-1:0] ref_cnt_q;
  logic [CW-1:0] target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ref_cnt_q <= '0;
    else if (!run_i)                   ref_cnt_q <= '0;
    else if (rise_i && ref_cnt_q != SAT) ref_cnt_q <= ref_cnt_q + 1'b1;
  end

  assign target = warm_i ? WARM_T : COLD_T;
  assign done_o = run_i && (ref_cnt_q >= target);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_on_i,
  input  logic       stalled_i,
  input  logic       edge_i,
  input  logic       lock_done_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!mode_on_i) begin
      state_d = SEQ_OFF;
    end else begin
      unique case (state_q)
        SEQ_OFF:   if (!stalled_i) state_d = SEQ_COLD;
        SEQ_COLD,
        SEQ_WARM: begin
          if (stalled_i)        state_d = SEQ_STALL;
          else if (lock_done_i) state_d = SEQ_READY;
        end
        SEQ_READY: if (stalled_i) state_d = SEQ_STALL;
        SEQ_STALL: if (edge_i)    state_d = SEQ_WARM;
        default:   state_d = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_OFF;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STALL_CYC   = 16,
  parameter int COLD_WAIT   = 2048,
  parameter int WARM_WAIT   = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk_in,
  input  logic [1:0] mode_sel,
  output logic       pll_en,
  output logic       sio_en,
  output logic       refs_en,
  output logic       data_valid,
  output logic [2:0] seq_state
);
  logic       ref_rise, ref_edge, stalled, lock_done;
  logic [1:0] mode_s;
  logic       mode_raw_on;
  logic       powered;
  seq_state_e state;

  ref_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_raw(ref_clk_in),
    .rise_o (ref_rise),
    .edge_o (ref_edge)
  );

  seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_mode_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (mode_sel),
    .q    (mode_s)
  );

  ref_stall_mon #(.STALL_CYC(STALL_CYC)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (ref_edge),
    .stalled_o(stalled)
  );

  lock_timer #(.COLD_WAIT(COLD_WAIT), .WARM_WAIT(WARM_WAIT)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state == SEQ_COLD || state == SEQ_WARM),
    .warm_i(state == SEQ_WARM),
    .rise_i(ref_rise),
    .done_o(lock_done)
  );

  seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_on_i  (|mode_s),
    .stalled_i  (stalled),
    .edge_i     (ref_edge),
    .lock_done_i(lock_done),
    .state_o    (state)
  );

  // Mode 0 removes PLL power straight from the pin, ahead of the synchronizer.
  assign mode_raw_on = |mode_sel;
  assign powered     = (state == SEQ_COLD) || (state == SEQ_WARM) || (state == SEQ_READY);
  assign pll_en      = powered && mode_raw_on;
  assign sio_en      = powered && mode_raw_on;
  assign refs_en     = (state != SEQ_OFF);
  assign data_valid  = (state == SEQ_READY) && mode_raw_on;
  assign seq_state   = state;
endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk
  import pll_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       pll_en,
  input logic       sio_en,
  input logic       refs_en,
  input logic       data_valid,
  input logic [2:0] seq_state
);
  AST_MODE0_CUTS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd0) |-> (!pll_en && !sio_en && !data_valid)); // R1

  AST_VALID_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (pll_en && sio_en && refs_en)); // R3

  AST_READY_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_READY && $past(seq_state) != SEQ_READY) |->
      ($past(seq_state) == SEQ_COLD || $past(seq_state) == SEQ_WARM)); // R3

  AST_STALL_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_STALL && $past(seq_state) != SEQ_STALL) |->
      ($past(seq_state) != SEQ_OFF)); // R4

  AST_STALL_KEEPS_REFS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_STALL) |-> (refs_en && !pll_en && !sio_en)); // R5

  AST_WARM_FROM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_WARM && $past(seq_state) != SEQ_WARM) |->
      ($past(seq_state) == SEQ_STALL)); // R6

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 3'd4); // R8
endmodule

bind pll_pwr_seq pll_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .pll_en    (pll_en),
  .sio_en    (sio_en),
  .refs_en   (refs_en),
  .data_valid(data_valid),
  .seq_state (seq_state)
);

// File: tb/test_pll_pwr_seq.sv
module test_pll_pwr_seq;
  localparam int B_STALL = 8;
  localparam int B_COLD  = 12;
  localparam int B_WARM  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk_in = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       pll_en, sio_en, refs_en, data_valid;
  logic [2:0] seq_state;

  int checks = 0;
  int errors = 0;

  pll_pwr_seq #(
    .SYNC_STAGES(2), .STALL_CYC(B_STALL), .COLD_WAIT(B_COLD), .WARM_WAIT(B_WARM)
  ) i_pll_pwr_seq (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .mode_sel(mode_sel),
    .pll_en(pll_en), .sio_en(sio_en), .refs_en(refs_en),
    .data_valid(data_valid), .seq_state(seq_state)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_period();
    ref_clk_in = 1'b1; tick(2);
    ref_clk_in = 1'b0; tick(2);
  endtask

  task automatic enables(input string req, input logic [3:0] exp);
    chk(req, {pll_en, sio_en, refs_en, data_valid}, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R8 state in reset", seq_state, 0);
    enables("R8 outputs in reset", 4'b0000);
    rst_n = 1'b1;
    tick(2);
    chk("R8 state after reset", seq_state, 0);

    // Nonzero mode but reference silent: must stay off.
    mode_sel = 2'd1;
    tick(5);
    chk("R2 stalled ref keeps off", seq_state, 0);
    enables("R2 stalled ref enables", 4'b0000);

    for (int m = 1; m <= 3; m++) begin
      mode_sel = 2'd0;
      tick(4);
      chk("R1 off after mode 0", seq_state, 0);
      chk("R1 refs low in off", refs_en, 0);
      ref_period(); ref_period();
      mode_sel = 2'(m);
      tick(4);
      chk("R2 R10 cold entry", seq_state, 1);
      enables("R2 R10 cold enables", 4'b1110);

      if (m == 3) begin
        mode_sel = 2'd0;
        #1;
        enables("R1 immediate cut in cold", 4'b0010);
        tick(4);
        chk("R1 cold to off", seq_state, 0);
        continue;
      end

      for (int p = 0; p < B_COLD - 1; p++) ref_period();
      tick(3);
      chk("R3 not ready after COLD_WAIT-1", seq_state, 1);
      chk("R3 no valid early", data_valid, 0);
      ref_period();
      tick(1);
      chk("R3 ready after COLD_WAIT", seq_state, 3);
      enables("R3 ready enables", 4'b1111);

      if (m == 2) begin
        mode_sel = 2'd0;
        #1;
        enables("R1 immediate cut in ready", 4'b0010);
        tick(4);
        chk("R1 ready to off", seq_state, 0);
        continue;
      end

      // Hold reference low: last falling edge was 3 ticks ago.
      tick(B_STALL - 1);
      chk("R4 ready just before stall", seq_state, 3);
      tick(3);
      chk("R4 stall held low", seq_state, 4);
      enables("R5 stalled enables", 4'b0010);

      ref_clk_in = 1'b1;
      tick(3);
      chk("R6 warm on first edge", seq_state, 2);
      chk("R6 pll on in warm", pll_en, 1);
      ref_clk_in = 1'b0;
      tick(2);
      for (int p = 0; p < B_WARM - 1; p++) ref_period();
      tick(3);
      chk("R7 not ready after WARM_WAIT-1", seq_state, 2);
      ref_period();
      tick(1);
      chk("R7 ready after WARM_WAIT", seq_state, 3);
      chk("R7 valid after warm", data_valid, 1);

      ref_clk_in = 1'b1;
      tick(B_STALL + 2);
      chk("R4 ready before stall high", seq_state, 3);
      tick(3);
      chk("R4 stall held high", seq_state, 4);
      enables("R5 stalled high enables", 4'b0010);

      mode_sel = 2'd0;
      tick(4);
      chk("R9 stall to off", seq_state, 0);
      chk("R9 refs low", refs_en, 0);
      ref_clk_in = 1'b0;
      tick(2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule